// File: doc/BRIEF.md
# Multi-Line Serial Transmit Scanner

This block is the transmit half of a serial multiplexer that drives several lines. A single shared data register feeds all the lines. A round-robin scanner walks over the lines that software has enabled. It stops at the first line whose serial shifter is idle, raises a ready flag and publishes that line's number. The host then writes one character, which goes to that line's shifter. There is no output queue: each ready indication takes exactly one character.

The host reaches the block through a small synchronous register port with three words. The control/status word holds a master scan enable, an interrupt enable, the read-only ready flag and the read-only line number, which sits at bit 8 upward. The enable word has one bit per line. The data word is write-only. If the scanner offers a line the host does not want to serve, the host clears that line's enable bit and the scanner moves on. Each line has a shifter model with fixed timing. It sends one start bit (0), the data bits least significant first and one stop bit (1). Each bit is held for a fixed number of clock cycles, and the line rests high between frames.

Top module: `mux_tx_scan`

## Requirements
- R1: After a synchronous reset, every register word reads as zero, the ready flag and the interrupt are low, and every serial output is high.
- R2: The enable word (address 1) reads back the value last written, one bit per line with bit n for line n. A line whose bit reads zero is not being serviced and counts as transmit-empty.
- R3: While the master scan enable (control bit 0) is zero, the ready flag stays low. If scan enable is cleared while ready is high, ready drops on the next clock edge.
- R4: A line is eligible when its enable bit is set and its shifter is idle. One clock edge after some line is eligible with scan enabled, the ready flag (control bit 7) sets and the control field at bits 8 upward names an eligible line.
- R5: A write to the data word (address 2) while ready is high loads the low data bits into the reported line's shifter. The same clock edge drops ready and the interrupt, and the start bit appears on that line.
- R6: A write to the data word while ready is low has no effect: no shifter starts and ready stays low.
- R7: While ready is high, the reported line stays fixed until it is served or loses eligibility. If its enable bit is cleared, ready drops and the scan resumes with the next line in order.
- R8: The interrupt output is high exactly when the ready flag and the interrupt enable (control bit 1) are both set, and it changes on the same clock edge as they do.
- R9: A loaded line sends a frame of start bit 0, the data bits least significant first, and stop bit 1, each held BIT_CYCLES cycles. The line is not eligible again until the stop bit has finished.
- R10: After a line is served or skipped, the next line reported is the first eligible line after it in increasing order, wrapping from the last line to line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select: 0 control/status, 1 line enable, 2 data |
| host_wdata | input | REG_W | Write data |
| host_rdata | output | REG_W | Registered read data for host_addr of the previous cycle |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_serial | output | NUM_LINES | Serial output of each line, idle high |

## Verification
Suppose the scanner's pointer or held line number is corrupted. The line field read back through the control word then names the wrong line, or a line is skipped. That shows on the next read and, one frame later, as a frame on an unexpected serial output. Suppose instead a shifter's busy state is wrong. The serial waveform then departs from the expected bit within one bit time, and the ready flag rises early or late, which the interrupt shows in the same cycle. Suppose a write is accepted when it should not be, or a ready flag sticks. A frame then starts on a line that should stay high, or the interrupt stays high after a data write, both visible one edge later.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  typedef enum logic [1:0] {
    REG_CSR   = 2'd0,
    REG_TXEN  = 2'd1,
    REG_TXDAT = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam int CSR_SCAN_BIT = 0;
  localparam int CSR_TIE_BIT  = 1;
  localparam int CSR_RDY_BIT  = 7;
  localparam int CSR_LINE_LSB = 8;
endpackage

// File: rtl/mxs_rr_pick.sv
module mxs_rr_pick #(
  parameter int N  = 4,
  parameter int LW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [LW-1:0] start_i,
  output logic          found_o,
  output logic [LW-1:0] idx_o
);
  // Lowest offset from start wins; loop runs downward so the nearest overrides.
  always_comb begin
    found_o = 1'b0;
    idx_o   = start_i;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(start_i) + k) % N;
      if (req_i[j]) begin
        found_o = 1'b1;
        idx_o   = LW'(j);
      end
    end
  end
endmodule

// File: rtl/mxs_line_shifter.sv
module mxs_line_shifter #(
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              serial_o
);
  localparam int FRAME = DATA_W + 2;
  localparam int CW    = $clog2(FRAME + 1);
  localparam int TW    = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;

  logic [FRAME-1:0] shreg_q;
  logic [CW-1:0]    left_q;
  logic [TW-1:0]    tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '1;
      left_q  <= '0;
      tick_q  <= '0;
    end else if (load_i) begin
      shreg_q <= {1'b1, data_i, 1'b0};
      left_q  <= CW'(FRAME);
      tick_q  <= TW'(BIT_CYCLES - 1);
    end else if (left_q != '0) begin
      if (tick_q == '0) begin
        shreg_q <= {1'b1, shreg_q[FRAME-1:1]};
        left_q  <= left_q - 1'b1;
        tick_q  <= TW'(BIT_CYCLES - 1);
      end else begin
        tick_q  <= tick_q - 1'b1;
      end
    end
  end

  assign busy_o   = (left_q != '0);
  assign serial_o = shreg_q[0];

  // R9
  shifter_idle_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !busy_o);
  // R9
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> serial_o);
  // R9
  stop_bit_high_chk: assert property (@(posedge clk) disable iff (rst)
    (left_q == CW'(1)) |-> serial_o);
endmodule

// File: rtl/mxs_scan_ctrl.sv
module mxs_scan_ctrl #(
  parameter int N  = 4,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scan_en_i,
  input  logic          tie_next_i,
  input  logic [N-1:0]  txen_i,
  input  logic [N-1:0]  busy_i,
  input  logic          data_wr_i,
  output logic          ready_o,
  output logic [LW-1:0] line_o,
  output logic          irq_o,
  output logic [N-1:0]  load_o
);
  logic [N-1:0]  elig;
  logic          found;
  logic [LW-1:0] pick_idx;
  logic          ready_q, ready_d, irq_q;
  logic [LW-1:0] line_q, line_d, ptr_q, ptr_d, line_next;

  assign elig      = txen_i & ~busy_i;
  assign line_next = (line_q == LW'(N - 1)) ? '0 : line_q + 1'b1;

  mxs_rr_pick #(.N(N), .LW(LW)) u_pick (
    .req_i   (elig),
    .start_i (ptr_q),
    .found_o (found),
    .idx_o   (pick_idx)
  );

  always_comb begin
    ready_d = ready_q;
    line_d  = line_q;
    ptr_d   = ptr_q;
    load_o  = '0;
    if (ready_q) begin
      if (data_wr_i) begin
        ready_d        = 1'b0;
        ptr_d          = line_next;
        load_o[line_q] = 1'b1;
      end else if (!scan_en_i || !elig[line_q]) begin
        ready_d = 1'b0;
        ptr_d   = line_next;
      end
    end else if (scan_en_i && found) begin
      ready_d = 1'b1;
      line_d  = pick_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      line_q  <= '0;
      ptr_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      ready_q <= ready_d;
      line_q  <= line_d;
      ptr_q   <= ptr_d;
      irq_q   <= ready_d & tie_next_i;
    end
  end

  assign ready_o = ready_q;
  assign line_o  = line_q;
  assign irq_o   = irq_q;

  // R5
  ready_drop_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && data_wr_i) |=> !ready_q);
  // R5
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_o));
  // R3
  no_scan_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!scan_en_i && !data_wr_i) |=> !ready_q);
  // R4
  rise_on_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> ((($past(elig)) >> line_q) & N'(1)) != '0);
  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && $past(ready_q)) |-> $stable(line_q));
endmodule

// File: rtl/mux_tx_scan.sv
module mux_tx_scan #(
  parameter int NUM_LINES  = 4,
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 4,
  parameter int REG_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_we,
  input  logic [1:0]           host_addr,
  input  logic [REG_W-1:0]     host_wdata,
  output logic [REG_W-1:0]     host_rdata,
  output logic                 tx_irq,
  output logic [NUM_LINES-1:0] tx_serial
);
  import mxs_pkg::*;

  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic                 scan_q, tie_q, tie_d;
  logic [NUM_LINES-1:0] txen_q, busy, load;
  logic                 csr_wr, txen_wr, data_wr;
  logic                 ready;
  logic [LW-1:0]        line;
  logic [REG_W-1:0]     rdata_d, rdata_q;
  logic                 unused_wdata;

  assign csr_wr       = host_we && (host_addr == REG_CSR);
  assign txen_wr      = host_we && (host_addr == REG_TXEN);
  assign data_wr      = host_we && (host_addr == REG_TXDAT);
  assign tie_d        = csr_wr ? host_wdata[CSR_TIE_BIT] : tie_q;
  assign unused_wdata = ^host_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q <= 1'b0;
      tie_q  <= 1'b0;
      txen_q <= '0;
    end else begin
      tie_q <= tie_d;
      if (csr_wr)  scan_q <= host_wdata[CSR_SCAN_BIT];
      if (txen_wr) txen_q <= host_wdata[NUM_LINES-1:0];
    end
  end

  mxs_scan_ctrl #(.N(NUM_LINES), .LW(LW)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .scan_en_i  (scan_q),
    .tie_next_i (tie_d),
    .txen_i     (txen_q),
    .busy_i     (busy),
    .data_wr_i  (data_wr),
    .ready_o    (ready),
    .line_o     (line),
    .irq_o      (tx_irq),
    .load_o     (load)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    mxs_line_shifter #(.DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .load_i   (load[g]),
      .data_i   (host_wdata[DATA_W-1:0]),
      .busy_o   (busy[g]),
      .serial_o (tx_serial[g])
    );
  end

  always_comb begin
    rdata_d = '0;
    case (reg_sel_e'(host_addr))
      REG_CSR: begin
        rdata_d[CSR_SCAN_BIT]           = scan_q;
        rdata_d[CSR_TIE_BIT]            = tie_q;
        rdata_d[CSR_RDY_BIT]            = ready;
        rdata_d[CSR_LINE_LSB +: LW]     = line;
      end
      REG_TXEN: rdata_d[NUM_LINES-1:0] = txen_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end
  assign host_rdata = rdata_q;

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq == (ready && tie_q));
  // R6
  idle_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !ready) |-> (load == '0));
endmodule

// File: tb/test_mux_tx_scan.sv
module test_mux_tx_scan;
  localparam int NL    = 4;
  localparam int DW    = 8;
  localparam int BC    = 4;
  localparam int FRAME = DW + 2;
  localparam int TOTAL = FRAME * BC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        tx_irq;
  logic [NL-1:0] tx_serial;

  int tests = 0;
  int fails = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mux_tx_scan #(.NUM_LINES(NL), .DATA_W(DW), .BIT_CYCLES(BC), .REG_W(16)) i_mux_tx_scan (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_irq(tx_irq), .tx_serial(tx_serial)
  );

  // reference model state
  bit          m_scan, m_tie, m_ready, m_irq;
  logic [NL-1:0] m_en;
  int          m_line, m_ptr, m_rd_addr;
  int          m_left [NL];
  logic [7:0]  m_char [NL];
  logic [15:0] m_rd;

  function automatic int pick(logic [NL-1:0] el, int start);
    for (int k = 0; k < NL; k++) begin
      int j = (start + k) % NL;
      if (el[j]) return j;
    end
    return -1;
  endfunction

  function automatic bit exp_serial(int left, logic [7:0] ch);
    int j;
    if (left == 0) return 1'b1;
    j = (TOTAL - left) / BC;
    if (j == 0) return 1'b0;
    if (j == FRAME - 1) return 1'b1;
    return ch[j-1];
  endfunction

  function automatic logic [15:0] csr_val(bit s, bit t, bit r, int ln);
    logic [15:0] v = '0;
    v[0] = s; v[1] = t; v[7] = r; v[9:8] = 2'(ln);
    return v;
  endfunction

  always @(posedge clk) begin : model
    logic [NL-1:0] el;
    bit dwr, cwr, ewr, n_ready, n_tie, ld;
    int n_line, n_ptr, p;
    if (rst) begin
      m_scan <= 0; m_tie <= 0; m_ready <= 0; m_irq <= 0; m_en <= '0;
      m_line <= 0; m_ptr <= 0; m_rd <= '0; m_rd_addr <= 0;
      for (int i = 0; i < NL; i++) begin m_left[i] <= 0; m_char[i] <= '0; end
    end else begin
      dwr = host_we && host_addr == 2'd2;
      cwr = host_we && host_addr == 2'd0;
      ewr = host_we && host_addr == 2'd1;
      for (int i = 0; i < NL; i++) el[i] = m_en[i] && m_left[i] == 0;
      n_ready = m_ready; n_line = m_line; n_ptr = m_ptr; ld = 0;
      if (m_ready) begin
        if (dwr) begin n_ready = 0; n_ptr = (m_line + 1) % NL; ld = 1; end
        else if (!m_scan || !el[m_line]) begin n_ready = 0; n_ptr = (m_line + 1) % NL; end
      end else if (m_scan) begin
        p = pick(el, m_ptr);
        if (p >= 0) begin n_ready = 1; n_line = p; end
      end
      n_tie = cwr ? host_wdata[1] : m_tie;
      m_rd_addr <= int'(host_addr);
      case (host_addr)
        2'd0: m_rd <= csr_val(m_scan, m_tie, m_ready, m_line);
        2'd1: m_rd <= {12'd0, m_en};
        default: m_rd <= '0;
      endcase
      for (int i = 0; i < NL; i++) begin
        if (ld && i == m_line) begin
          m_left[i] <= TOTAL; m_char[i] <= host_wdata[7:0];
        end else if (m_left[i] > 0) m_left[i] <= m_left[i] - 1;
      end
      m_ready <= n_ready; m_line <= n_line; m_ptr <= n_ptr; m_tie <= n_tie;
      m_irq <= n_ready && n_tie;
      if (cwr) m_scan <= host_wdata[0];
      if (ewr) m_en <= host_wdata[NL-1:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !rst) begin
      chk(host_rdata == m_rd, (m_rd_addr == 1) ? "R2 enable readback" : "R4 status readback",
          32'(host_rdata), 32'(m_rd));
      chk(tx_irq == m_irq, "R8 interrupt", 32'(tx_irq), 32'(m_irq));
      for (int i = 0; i < NL; i++)
        chk(tx_serial[i] == exp_serial(m_left[i], m_char[i]), "R9 serial frame",
            32'(tx_serial[i]), 32'(exp_serial(m_left[i], m_char[i])));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    host_addr = a;
    @(negedge clk);
    v = host_rdata;
    host_addr = 2'd0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    int ln;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_on = 1'b1;
    // R1 reset state
    chk(host_rdata == 16'h0, "R1 reset status", 32'(host_rdata), 0);
    chk(tx_irq == 1'b0, "R1 reset irq", 32'(tx_irq), 0);
    chk(tx_serial == '1, "R1 reset serial high", 32'(tx_serial), 32'hF);
    rd(2'd1, v);
    chk(v == 16'h0, "R1 reset enable word", 32'(v), 0);

    // R3 no scanning without master enable
    wr(2'd1, 16'h000F);
    idle(6);
    rd(2'd0, v);
    chk(v[7] == 1'b0, "R3 ready low with scan off", 32'(v[7]), 0);

    // R4 / R8 first report
    wr(2'd0, 16'h0003);
    idle(1);
    chk(tx_irq == 1'b1, "R8 irq with ready and enable", 32'(tx_irq), 1);
    idle(1);
    chk(host_rdata[7] == 1'b1 && host_rdata[9:8] == 2'd0, "R4 ready on line 0",
        32'(host_rdata), 32'h0083);

    // R10 round robin after serving
    wr(2'd2, 16'h00A5);
    chk(tx_serial[0] == 1'b0, "R5 start bit on served line", 32'(tx_serial[0]), 0);
    chk(tx_irq == 1'b0, "R5 irq drops on write", 32'(tx_irq), 0);
    idle(2);
    chk(host_rdata[9:8] == 2'd1 && host_rdata[7], "R10 next line 1", 32'(host_rdata), 32'h0183);
    wr(2'd2, 16'h003C);
    idle(2);
    chk(host_rdata[9:8] == 2'd2 && host_rdata[7], "R10 next line 2", 32'(host_rdata), 32'h0283);

    // R7 skip the reported line by clearing its enable
    wr(2'd1, 16'h000B);
    idle(3);
    chk(host_rdata[9:8] == 2'd3 && host_rdata[7], "R7 skip to line 3", 32'(host_rdata), 32'h0383);
    wr(2'd2, 16'h005A);
    idle(2);
    chk(host_rdata[7] == 1'b0, "R9 busy lines not eligible", 32'(host_rdata[7]), 0);

    // R6 data write while not ready is ignored
    wr(2'd1, 16'h0000);
    idle(TOTAL + 5);
    wr(2'd2, 16'h00FF);
    idle(5);
    chk(tx_serial == '1, "R6 ignored write leaves lines idle", 32'(tx_serial), 32'hF);
    rd(2'd0, v);
    chk(v[7] == 1'b0, "R6 ready stays low", 32'(v[7]), 0);

    // R2 enable readback
    wr(2'd1, 16'h0006);
    rd(2'd1, v);
    chk(v == 16'h0006, "R2 enable readback", 32'(v), 32'h6);

    // R5 serve whichever line is reported
    idle(3);
    rd(2'd0, v);
    ln = int'(v[9:8]);
    wr(2'd2, 16'h0081);
    chk(tx_irq == 1'b0, "R5 irq low after write", 32'(tx_irq), 0);
    chk(tx_serial[ln] == 1'b0, "R5 start bit", 32'(tx_serial[ln]), 0);

    // R8 interrupt masked
    wr(2'd0, 16'h0001);
    idle(3);
    chk(tx_irq == 1'b0, "R8 irq masked", 32'(tx_irq), 0);
    wr(2'd0, 16'h0003);

    // random phase
    for (int c = 0; c < 20000; c++) begin
      int r = int'($urandom % 100);
      if (r < 6) wr(2'd1, 16'($urandom % 16));
      else if (r < 9) wr(2'd0, {14'd0, 1'($urandom), ($urandom % 8) != 0});
      else if (r < 40 && m_ready) wr(2'd2, 16'($urandom));
      else if (r < 43) wr(2'd2, 16'($urandom));
      else if (r < 70) rd(2'($urandom), v);
      else idle(1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule